// File: doc/BRIEF.md
# Score-Replaced Set-Associative Translation Buffer

This block caches virtual-to-physical page translations for 4 KiB pages. It holds 32 entries arranged as 8 sets of 4 ways. A lookup presents a virtual address. In the same cycle the block answers with a hit flag and the physical page number, straight from its registered arrays. After a page walk, the fill port installs a translation. The fill port takes the page entry word that the walker produced, and that word carries the physical page number and a global flag.

Each entry keeps an 8-bit usage score. A lookup hit raises the score by one, and the score stops at 255. When a fill finds every way of its set occupied, it evicts the way whose score is lowest. Software-driven maintenance comes in three forms: a full flush, a flush that spares global entries, and an invalidate of a single page.

Each cycle, the control inputs are decoded into one operation. The operations are OP_IDLE, OP_FLUSH_ALL, OP_FLUSH_LOCAL, OP_INVAL and OP_FILL, with the priority flush, then invalidate, then fill. The chosen operation takes effect at the next clock edge. The block holds no multi-cycle state, so every operation is a transition from the array contents to the new contents in a single cycle.

Top module: `score_xlate_buf`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses.
- R2: A lookup with `lk_valid` high uses `lk_vaddr[14:12]` as the set index. It hits when a valid entry in that set holds a tag equal to `lk_vaddr[31:12]`. `lk_hit` and `lk_ppage` respond combinationally in the same cycle. On a miss, `lk_ppage` reads zero.
- R3: Each lookup hit adds one to the hit entry's score at the clock edge. The score saturates at 255 and does not wrap.
- R4: A fill writes into the lowest-numbered invalid way of set `fill_vaddr[14:12]`.
- R5: When all four ways of the set are valid, a fill replaces the way with the smallest score. If scores are equal, the highest-numbered way among them is replaced.
- R6: A filled entry becomes valid with score 0 and tag `fill_vaddr[31:12]`. Its physical page comes from `fill_pte[31:12]` and its global flag from `fill_pte[8]`.
- R7: `flush_en` with `flush_all` high invalidates every entry.
- R8: `flush_en` with `flush_all` low invalidates only entries whose global flag is clear. Global entries keep translating.
- R9: `inv_en` invalidates only the valid entry of set `inv_vaddr[14:12]` whose tag equals `inv_vaddr[31:12]`. When no entry matches, nothing changes.
- R10: When several operations are requested in the same cycle, only one is performed, with the priority flush, then invalidate, then fill. Every request that loses has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_ppage | output | 20 | Physical page number of the hit entry |
| fill_en | input | 1 | Install a translation |
| fill_vaddr | input | 32 | Virtual address being installed |
| fill_pte | input | 32 | Page entry word: page number [31:12], global [8] |
| flush_en | input | 1 | Flush request |
| flush_all | input | 1 | Flush also removes global entries |
| inv_en | input | 1 | Single-page invalidate request |
| inv_vaddr | input | 32 | Virtual address to invalidate |

## Verification
The bench drives scores to tie at the saturation ceiling. A design that wraps its counters would then evict an entry whose count had rolled over to a small value, instead of the top way. Separate tests check victim choice in three cases: two holes in one set, a tie at zero scores, and scores that all differ. A design that picks the wrong hole or breaks ties toward the low way would lose the wrong translation. Same-cycle collisions are also covered: flush against fill, invalidate against fill, and a flush that spares globals against an invalidate of a global entry. A design with the wrong priority would leave a page present that should be gone, or remove a page that should survive.

// File: rtl/xbuf_pkg.sv
`timescale 1ns/1ps
package xbuf_pkg;

    // One operation is applied per clock edge, chosen by priority.
    typedef enum logic [2:0] {
        OP_IDLE        = 3'd0,
        OP_FLUSH_ALL   = 3'd1,
        OP_FLUSH_LOCAL = 3'd2,
        OP_INVAL       = 3'd3,
        OP_FILL        = 3'd4
    } xbuf_op_e;

endpackage

// File: rtl/xbuf_op_decode.sv
`timescale 1ns/1ps
module xbuf_op_decode
    import xbuf_pkg::*;
(
    input  logic     flush_en,
    input  logic     flush_all,
    input  logic     inv_en,
    input  logic     fill_en,
    output xbuf_op_e op
);

    // Flush beats invalidate, invalidate beats fill (R10).
    always_comb begin
        if (flush_en)
            op = flush_all ? OP_FLUSH_ALL : OP_FLUSH_LOCAL;
        else if (inv_en)
            op = OP_INVAL;
        else if (fill_en)
            op = OP_FILL;
        else
            op = OP_IDLE;
    end

endmodule

// File: rtl/xbuf_way_match.sv
`timescale 1ns/1ps
module xbuf_way_match #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 20
) (
    input  logic [NUM_WAYS-1:0]            valid,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]               key,
    output logic [NUM_WAYS-1:0]            match
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == key);
    end

endmodule

// File: rtl/xbuf_victim.sv
`timescale 1ns/1ps
module xbuf_victim #(
    parameter int NUM_WAYS = 4,
    parameter int SCORE_W  = 8,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0]              valid,
    input  logic [NUM_WAYS-1:0][SCORE_W-1:0] scores,
    output logic [WAY_W-1:0]                 victim
);

    logic               have_hole;
    logic [WAY_W-1:0]   hole_way;
    logic [WAY_W-1:0]   low_way;
    logic [SCORE_W-1:0] low_score;

    always_comb begin
        have_hole = 1'b0;
        hole_way  = '0;
        // Walk downward so the lowest-numbered hole is kept last (R4).
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                have_hole = 1'b1;
                hole_way  = WAY_W'(w);
            end
        end
        low_way   = '0;
        low_score = '1;
        // "<=" lets a later, higher way take a tie (R5).
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (scores[w] <= low_score) begin
                low_score = scores[w];
                low_way   = WAY_W'(w);
            end
        end
        victim = have_hole ? hole_way : low_way;
    end

endmodule

// File: rtl/score_xlate_buf.sv
`timescale 1ns/1ps
module score_xlate_buf
    import xbuf_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int NUM_SETS   = 8,
    parameter int NUM_WAYS   = 4,
    parameter int SCORE_W    = 8,
    parameter int GLOBAL_BIT = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [VA_W-1:0]          lk_vaddr,
    output logic                     lk_hit,
    output logic [PA_W-PAGE_SHIFT-1:0] lk_ppage,
    input  logic                     fill_en,
    input  logic [VA_W-1:0]          fill_vaddr,
    input  logic [PA_W-1:0]          fill_pte,
    input  logic                     flush_en,
    input  logic                     flush_all,
    input  logic                     inv_en,
    input  logic [VA_W-1:0]          inv_vaddr
);

    localparam int SET_W = $clog2(NUM_SETS);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int TAG_W = VA_W - PAGE_SHIFT;
    localparam int PPN_W = PA_W - PAGE_SHIFT;
    localparam logic [SCORE_W-1:0] SCORE_MAX = '1;

    // Entry storage, one row per set.
    logic [NUM_WAYS-1:0]              valid_q  [NUM_SETS];
    logic [NUM_WAYS-1:0]              global_q [NUM_SETS];
    logic [NUM_WAYS-1:0][SCORE_W-1:0] score_q  [NUM_SETS];
    logic [NUM_WAYS-1:0][TAG_W-1:0]   tag_q    [NUM_SETS];
    logic [NUM_WAYS-1:0][PPN_W-1:0]   ppn_q    [NUM_SETS];

    xbuf_op_e op;

    logic [SET_W-1:0]    lk_set, fill_set, inv_set;
    logic [TAG_W-1:0]    lk_tag, fill_tag, inv_tag;
    logic [NUM_WAYS-1:0] lk_match, inv_match;
    logic [WAY_W-1:0]    lk_way;
    logic [WAY_W-1:0]    vict_way;
    logic                unused_bits;

    assign lk_set   = lk_vaddr[PAGE_SHIFT +: SET_W];
    assign fill_set = fill_vaddr[PAGE_SHIFT +: SET_W];
    assign inv_set  = inv_vaddr[PAGE_SHIFT +: SET_W];
    assign lk_tag   = lk_vaddr[VA_W-1:PAGE_SHIFT];
    assign fill_tag = fill_vaddr[VA_W-1:PAGE_SHIFT];
    assign inv_tag  = inv_vaddr[VA_W-1:PAGE_SHIFT];

    assign unused_bits = ^{lk_vaddr[PAGE_SHIFT-1:0], fill_vaddr[PAGE_SHIFT-1:0],
                           inv_vaddr[PAGE_SHIFT-1:0], fill_pte[PAGE_SHIFT-1:0]};

    xbuf_op_decode u_decode (
        .flush_en  (flush_en),
        .flush_all (flush_all),
        .inv_en    (inv_en),
        .fill_en   (fill_en),
        .op        (op)
    );

    xbuf_way_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_lk_match (
        .valid (valid_q[lk_set]),
        .tags  (tag_q[lk_set]),
        .key   (lk_tag),
        .match (lk_match)
    );

    xbuf_way_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_inv_match (
        .valid (valid_q[inv_set]),
        .tags  (tag_q[inv_set]),
        .key   (inv_tag),
        .match (inv_match)
    );

    xbuf_victim #(.NUM_WAYS(NUM_WAYS), .SCORE_W(SCORE_W)) u_victim (
        .valid  (valid_q[fill_set]),
        .scores (score_q[fill_set]),
        .victim (vict_way)
    );

    // Lookup output stage: lowest matching way drives the result.
    always_comb begin
        lk_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (lk_match[w]) lk_way = WAY_W'(w);
        end
        lk_hit   = lk_valid && (|lk_match);
        lk_ppage = lk_hit ? ppn_q[lk_set][lk_way] : '0;
    end

    // Array update: score bump on hit, then the decoded operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
        end else begin
            if (lk_hit && score_q[lk_set][lk_way] != SCORE_MAX)
                score_q[lk_set][lk_way] <= score_q[lk_set][lk_way] + 1'b1;
            unique case (op)
                OP_FLUSH_ALL: begin
                    for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
                end
                OP_FLUSH_LOCAL: begin
                    for (int s = 0; s < NUM_SETS; s++)
                        valid_q[s] <= valid_q[s] & global_q[s];
                end
                OP_INVAL: begin
                    valid_q[inv_set] <= valid_q[inv_set] & ~inv_match;
                end
                OP_FILL: begin
                    valid_q[fill_set][vict_way]  <= 1'b1;
                    global_q[fill_set][vict_way] <= fill_pte[GLOBAL_BIT];
                    score_q[fill_set][vict_way]  <= '0;
                    tag_q[fill_set][vict_way]    <= fill_tag;
                    ppn_q[fill_set][vict_way]    <= fill_pte[PA_W-1:PAGE_SHIFT];
                end
                OP_IDLE: ;
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    p_score_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit && op == OP_IDLE && score_q[lk_set][lk_way] != SCORE_MAX
        |=> score_q[$past(lk_set)][$past(lk_way)] ==
            SCORE_W'($past(score_q[lk_set][lk_way]) + 1'b1));

    p_score_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit && op == OP_IDLE && score_q[lk_set][lk_way] == SCORE_MAX
        |=> score_q[$past(lk_set)][$past(lk_way)] == SCORE_MAX);

    p_fill_hole_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en && !(&valid_q[fill_set]) |-> !valid_q[fill_set][vict_way]);

    p_fill_install_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FILL
        |=> valid_q[$past(fill_set)][$past(vict_way)] &&
            score_q[$past(fill_set)][$past(vict_way)] == '0);

    p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FLUSH_ALL |=> !lk_hit);

    p_inval_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_INVAL
        |=> valid_q[$past(inv_set)] == ($past(valid_q[inv_set]) & ~$past(inv_match)));

    p_fill_loses_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en && (flush_en || inv_en)
        |=> tag_q[$past(fill_set)][$past(vict_way)] == $past(tag_q[fill_set][vict_way]));

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk_set
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_chk_way
            p_keep_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
                op == OP_FLUSH_LOCAL && valid_q[s][w] && global_q[s][w]
                |=> valid_q[s][w]);
            p_drop_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
                op == OP_FLUSH_LOCAL && !global_q[s][w] |=> !valid_q[s][w]);
        end
    end

endmodule

// File: tb/score_xlate_buf_bench.sv
`timescale 1ns/1ps
module score_xlate_buf_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [19:0] lk_ppage;
    logic        fill_en = 1'b0;
    logic [31:0] fill_vaddr = '0;
    logic [31:0] fill_pte = '0;
    logic        flush_en = 1'b0;
    logic        flush_all = 1'b0;
    logic        inv_en = 1'b0;
    logic [31:0] inv_vaddr = '0;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    score_xlate_buf u_score_xlate_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_vaddr   (lk_vaddr),
        .lk_hit     (lk_hit),
        .lk_ppage   (lk_ppage),
        .fill_en    (fill_en),
        .fill_vaddr (fill_vaddr),
        .fill_pte   (fill_pte),
        .flush_en   (flush_en),
        .flush_all  (flush_all),
        .inv_en     (inv_en),
        .inv_vaddr  (inv_vaddr)
    );

    function automatic logic [31:0] pte(input logic [19:0] ppn, input logic glb);
        return {ppn, 3'b000, glb, 8'h00};
    endfunction

    // One lookup cycle; result sampled 1 ns after the driving negedge.
    task automatic look(input string req, input logic [31:0] va,
                        input logic exp_hit, input logic [19:0] exp_pp);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        #1;
        n_run++;
        if (lk_hit !== exp_hit || lk_ppage !== exp_pp) begin
            n_fail++;
            $display("FAIL %s va=%h hit=%b ppage=%h expected hit=%b ppage=%h",
                     req, va, lk_hit, lk_ppage, exp_hit, exp_pp);
        end
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Hold a hitting lookup for n consecutive edges.
    task automatic pump(input logic [31:0] va, input int n);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        repeat (n) @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // One cycle with any mix of operations requested.
    task automatic ops(input logic do_fill, input logic [31:0] fva, input logic [31:0] fpte,
                       input logic do_flush, input logic all,
                       input logic do_inv, input logic [31:0] iva);
        @(negedge clk);
        fill_en = do_fill; fill_vaddr = fva; fill_pte = fpte;
        flush_en = do_flush; flush_all = all;
        inv_en = do_inv; inv_vaddr = iva;
        @(negedge clk);
        fill_en = 1'b0; flush_en = 1'b0; flush_all = 1'b0; inv_en = 1'b0;
    endtask

    task automatic fill(input logic [31:0] va, input logic [19:0] ppn, input logic glb);
        ops(1'b1, va, pte(ppn, glb), 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_reset;
        look("R1 reset", 32'h0000_3000, 1'b0, '0);
        look("R1 reset", 32'hFFFF_F000, 1'b0, '0);
    endtask

    task automatic t_fill_lookup;
        fill(32'h0000_3000, 20'hABCDE, 1'b0);
        look("R2/R6 hit", 32'h0000_3123, 1'b1, 20'hABCDE);
        look("R2 tag mismatch", 32'h0010_3000, 1'b0, '0);
        look("R2 other set", 32'h0000_4000, 1'b0, '0);
    endtask

    task automatic t_first_invalid;
        fill(32'h0001_5000, 20'h000A1, 1'b0);
        fill(32'h0002_5000, 20'h000B1, 1'b0);
        fill(32'h0003_5000, 20'h000C1, 1'b0);
        fill(32'h0004_5000, 20'h000D1, 1'b0);
        ops(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 32'h0002_5000);
        ops(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 32'h0004_5000);
        fill(32'h0005_5000, 20'h000E1, 1'b0); // must land in way 1
        fill(32'h0006_5000, 20'h000F1, 1'b0); // then way 3
        fill(32'h0007_5000, 20'h00071, 1'b0); // all zero scores: evicts way 3
        look("R4/R5 top way evicted on tie", 32'h0006_5000, 1'b0, '0);
        look("R4 lowest hole used", 32'h0005_5000, 1'b1, 20'h000E1);
        look("R5 new entry", 32'h0007_5000, 1'b1, 20'h00071);
        look("R4 untouched", 32'h0001_5000, 1'b1, 20'h000A1);
        look("R9 invalidated", 32'h0002_5000, 1'b0, '0);
    endtask

    task automatic t_score_min;
        for (int i = 0; i < 4; i++) fill(32'h0001_6000 + 32'(i) * 32'h10_0000, 20'h00600 + 20'(i), 1'b0);
        pump(32'h0001_6000, 3);
        pump(32'h0011_6000, 1);
        pump(32'h0021_6000, 2);
        pump(32'h0031_6000, 4);
        fill(32'h0041_6000, 20'h00644, 1'b0);
        look("R5 lowest score evicted", 32'h0011_6000, 1'b0, '0);
        look("R5 higher score kept", 32'h0001_6000, 1'b1, 20'h00600);
        look("R5 higher score kept", 32'h0021_6000, 1'b1, 20'h00602);
        look("R5 replacement present", 32'h0041_6000, 1'b1, 20'h00644);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 4; i++) fill(32'h0001_7000 + 32'(i) * 32'h10_0000, 20'h00700 + 20'(i), 1'b0);
        pump(32'h0001_7000, 300);
        pump(32'h0011_7000, 256);
        pump(32'h0021_7000, 255);
        pump(32'h0031_7000, 260);
        fill(32'h0041_7000, 20'h00777, 1'b0);
        look("R3 saturated tie evicts top way", 32'h0031_7000, 1'b0, '0);
        look("R3 no wrap way1", 32'h0011_7000, 1'b1, 20'h00701);
        look("R3 no wrap way0", 32'h0001_7000, 1'b1, 20'h00700);
        look("R3 way2 kept", 32'h0021_7000, 1'b1, 20'h00702);
    endtask

    task automatic t_invalidate;
        fill(32'h0001_2000, 20'h00201, 1'b0);
        fill(32'h0002_2000, 20'h00202, 1'b0);
        ops(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 32'h0009_2000);
        look("R9 no match keeps", 32'h0001_2000, 1'b1, 20'h00201);
        ops(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 32'h0001_2FFF);
        look("R9 match cleared", 32'h0001_2000, 1'b0, '0);
        look("R9 neighbour kept", 32'h0002_2000, 1'b1, 20'h00202);
    endtask

    task automatic t_priority;
        fill(32'h0001_4000, 20'h00401, 1'b0);
        ops(1'b1, 32'h0002_4000, pte(20'h00402, 1'b0), 1'b1, 1'b1, 1'b0, '0);
        look("R10 flush beats fill", 32'h0002_4000, 1'b0, '0);
        look("R7 flushed", 32'h0001_4000, 1'b0, '0);
        fill(32'h0001_4000, 20'h00401, 1'b0);
        ops(1'b1, 32'h0003_4000, pte(20'h00403, 1'b0), 1'b0, 1'b0, 1'b1, 32'h0001_4000);
        look("R10 inval beats fill", 32'h0003_4000, 1'b0, '0);
        look("R10 inval applied", 32'h0001_4000, 1'b0, '0);
        fill(32'h0004_4000, 20'h00404, 1'b1);
        ops(1'b0, '0, '0, 1'b1, 1'b0, 1'b1, 32'h0004_4000);
        look("R10 flush beats inval", 32'h0004_4000, 1'b1, 20'h00404);
    endtask

    task automatic t_flush;
        fill(32'h0001_0000, 20'h00011, 1'b1);
        fill(32'h0002_0000, 20'h00012, 1'b0);
        fill(32'h0003_1000, 20'h00013, 1'b1);
        ops(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, '0);
        look("R8 global kept", 32'h0001_0000, 1'b1, 20'h00011);
        look("R8 global kept", 32'h0003_1000, 1'b1, 20'h00013);
        look("R8 local dropped", 32'h0002_0000, 1'b0, '0);
        look("R8 local dropped", 32'h0000_3000, 1'b0, '0);
        ops(1'b0, '0, '0, 1'b1, 1'b1, 1'b0, '0);
        look("R7 global dropped", 32'h0001_0000, 1'b0, '0);
        look("R7 global dropped", 32'h0003_1000, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_lookup();
        t_first_invalid();
        t_score_min();
        t_saturate();
        t_invalidate();
        t_priority();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired after %0d checks, expected completion", n_run);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule